// File: doc/BRIEF.md
# One-Shot Match Timer with Interrupt

This block is a 32-bit timer for an operating system's time base. It sits on a simple 32-bit register bus and has one level interrupt output. Software programs a target value into the match register. That write starts a single countdown whose length is the wrap-aware distance from the latched counter value to the new target. Each cycle in which the tick enable is high moves the run one step closer to the target.

When the run ends, the counter register is loaded with the target value and the run stops. If the interrupt-enable register holds any nonzero value, the status flag is set and the interrupt line goes high. The line stays high until software writes zero to the status register. A read of the counter at any time returns the target minus the ticks still left, so the visible count climbs by one per tick. The nominal tick rate is 50 MHz, supplied by the surrounding logic as the tick enable.

Bus responses come one cycle after the request: read data, and a one-cycle error flag for any access the block rejects.

Top module: `ostmr_top`

## Requirements
- R1: After reset the counter, status and interrupt-enable registers read as zero, the interrupt output is low and the match register holds zero.
- R2: A write of value M to offset 0x00 when M is greater than the latched counter C starts a run of exactly M − C ticks. At the end of that run, a read of offset 0x10 returns M.
- R3: A write of M to offset 0x00 when M ≤ C starts a run of M + 0xFFFFFFFF − C ticks, modulo 2^32. In that case a read of 0x10 right after the write returns C + 1.
- R4: During a run, a read of 0x10 returns the match value minus the ticks still to go. It rises by one for each cycle with the tick enable high and does not change on cycles without a tick.
- R5: At the end of a run the counter takes the match value and the run stops. Later ticks leave the counter unchanged until the next match write.
- R6: If the interrupt-enable register (offset 0x1C, all 32 bits stored) is nonzero at the end of a run, status (offset 0x14, bit 0) reads 1 and the interrupt output is high from the cycle after the final tick.
- R7: If the interrupt-enable register is zero at the end of a run, status stays 0 and the interrupt output stays low, while the counter still takes the match value.
- R8: A write of zero to 0x14 clears status and drops the interrupt output on the next cycle. A nonzero write to 0x14 is rejected: status is unchanged and the error flag pulses.
- R9: The interrupt output is a level that stays high until status is cleared. A new match write does not clear a pending status.
- R10: An access to an unmapped offset, to a misaligned address or with byte enables other than 4'hF, a read of 0x00 and a write of 0x10 all return zero read data, change no register and raise the error output for one cycle.
- R11: A match write in the same cycle as a tick takes priority: the new run is armed from the latched counter and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances a run by one step when high |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_be | input | 4 | Byte enables, only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after a read request, zero otherwise |
| err_o | output | 1 | One-cycle pulse the cycle after a rejected access |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The properties assume that each bus request lasts one cycle, that the address, enables and data are stable around the sampling edge, and that the interrupt can fall only through a legal status clear or reset. The bench drives every input on the falling edge and holds each request for exactly one cycle. It never issues a read in the same cycle as a tick, so each counter read sees a settled value. Runs that wrap through the top of the 32-bit range are checked through the counter value read back right after arming, not by waiting out billions of ticks.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    localparam int REG_W = 32;
    localparam int BE_W  = REG_W / 8;

    localparam int OFS_MATCH  = 'h00;
    localparam int OFS_COUNT  = 'h10;
    localparam int OFS_STATUS = 'h14;
    localparam int OFS_IEN    = 'h1C;

    typedef logic [REG_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_IEN
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic rd_ok;
        logic wr_ok;
        logic reject;
    } dec_t;

    // Ticks from the latched counter to the new target, wrapping through the top.
    function automatic word_t arm_distance(word_t target, word_t latched);
        word_t d;
        if (target > latched) d = target - latched;
        else                  d = target + {REG_W{1'b1}} - latched;
        return d;
    endfunction

endpackage

// File: rtl/ostmr_regdec.sv
module ostmr_regdec
    import ostmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  word_t             wdata,
    output dec_t              dec
);

    logic full_word;
    logic aligned;

    always_comb begin
        full_word = (be == {BE_W{1'b1}});
        aligned   = (addr[1:0] == 2'b00);
        dec       = '{sel: SEL_NONE, rd_ok: 1'b0, wr_ok: 1'b0, reject: 1'b0};
        if (full_word && aligned) begin
            if (addr == ADDR_W'(OFS_MATCH)) begin
                dec.sel   = SEL_MATCH;
                dec.wr_ok = write;
            end else if (addr == ADDR_W'(OFS_COUNT)) begin
                dec.sel   = SEL_COUNT;
                dec.rd_ok = !write;
            end else if (addr == ADDR_W'(OFS_STATUS)) begin
                dec.sel   = SEL_STATUS;
                dec.rd_ok = !write;
                dec.wr_ok = write && (wdata == '0);
            end else if (addr == ADDR_W'(OFS_IEN)) begin
                dec.sel   = SEL_IEN;
                dec.rd_ok = !write;
                dec.wr_ok = write;
            end
        end
        dec.reject = valid && !(dec.rd_ok || dec.wr_ok);
        if (!valid) begin
            dec.rd_ok = 1'b0;
            dec.wr_ok = 1'b0;
        end
    end

endmodule

// File: rtl/ostmr_countdown.sv
module ostmr_countdown
    import ostmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  arm,
    input  word_t arm_value,
    input  logic  tick,
    output logic  expire,
    output logic  running,
    output word_t count_view
);

    word_t match_q;
    word_t latched_q;
    word_t remain_q;
    logic  running_q;

    // A zero-length run (possible only after a wrap) ends on its first tick.
    assign expire     = running_q && tick && !arm && (remain_q <= word_t'(1));
    assign running    = running_q;
    assign count_view = match_q - remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q   <= '0;
            latched_q <= '0;
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (arm) begin
            match_q   <= arm_value;
            remain_q  <= arm_distance(arm_value, latched_q);
            running_q <= 1'b1;
        end else if (expire) begin
            latched_q <= match_q;
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (running_q && tick) begin
            remain_q  <= remain_q - word_t'(1);
        end
    end

endmodule

// File: rtl/ostmr_irqctl.sv
module ostmr_irqctl
    import ostmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ien_wr,
    input  word_t ien_wdata,
    input  logic  stat_clr,
    input  logic  expire,
    output word_t ien,
    output logic  ien_nz,
    output logic  status
);

    word_t ien_q;
    logic  status_q;

    assign ien    = ien_q;
    assign ien_nz = (ien_q != '0);
    assign status = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q    <= '0;
            status_q <= 1'b0;
        end else begin
            if (ien_wr) ien_q <= ien_wdata;
            // Setting on expiry wins over a clear in the same cycle.
            if (expire && ien_nz) status_q <= 1'b1;
            else if (stat_clr)    status_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data_o,
    output logic              err_o,
    output logic              irq_o
);

    dec_t  dec_w;
    logic  expire_w;
    logic  running_w;
    word_t count_w;
    word_t ien_w;
    logic  ien_nz_w;
    logic  status_w;
    word_t rdata_d;
    word_t rdata_q;
    logic  err_q;

    ostmr_regdec #(.ADDR_W(ADDR_W)) dec_i (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .be    (req_be),
        .wdata (req_wdata),
        .dec   (dec_w)
    );

    ostmr_countdown cd_i (
        .clk        (clk),
        .rst        (rst),
        .arm        (dec_w.wr_ok && dec_w.sel == SEL_MATCH),
        .arm_value  (req_wdata),
        .tick       (tick_en),
        .expire     (expire_w),
        .running    (running_w),
        .count_view (count_w)
    );

    ostmr_irqctl irq_i (
        .clk       (clk),
        .rst       (rst),
        .ien_wr    (dec_w.wr_ok && dec_w.sel == SEL_IEN),
        .ien_wdata (req_wdata),
        .stat_clr  (dec_w.wr_ok && dec_w.sel == SEL_STATUS),
        .expire    (expire_w),
        .ien       (ien_w),
        .ien_nz    (ien_nz_w),
        .status    (status_w)
    );

    always_comb begin
        rdata_d = '0;
        if (dec_w.rd_ok) begin
            case (dec_w.sel)
                SEL_COUNT:  rdata_d = count_w;
                SEL_STATUS: rdata_d = word_t'(status_w);
                SEL_IEN:    rdata_d = ien_w;
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rdata_d;
            err_q   <= dec_w.reject;
        end
    end

    assign rd_data_o = rdata_q;
    assign err_o     = err_q;
    assign irq_o     = status_w;

endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk
    import ostmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rd_data_o,
    input logic              err_o,
    input logic              irq_o,
    input logic              expire_w,
    input logic              running_w,
    input logic              ien_nz_w
);

    logic clear_req;
    assign clear_req = req_valid && req_write && req_be == 4'hF &&
                       req_addr == ADDR_W'(OFS_STATUS) && req_wdata == '0;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_o && !err_o && rd_data_o == '0));

    assert_run_stops_R5: assert property (@(posedge clk) disable iff (rst)
        expire_w |=> !running_w);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(expire_w && ien_nz_w));

    assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !expire_w) |=> !irq_o);

    assert_irq_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clear_req) |=> irq_o);

    assert_err_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(req_valid));

endmodule

bind ostmr_top ostmr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rd_data_o (rd_data_o),
    .err_o     (err_o),
    .irq_o     (irq_o),
    .expire_w  (expire_w),
    .running_w (running_w),
    .ien_nz_w  (ien_nz_w)
);

// File: tb/ostmr_top_tb_top.sv
module ostmr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
        logic        experr;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD, 8'h1C, 32'd0, 4'hF, 32'd0, 1'b0, 8'd1},  // R1 enable reads 0
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd0, 1'b0, 8'd1},  // R1 counter reads 0
        '{OP_RD, 8'h14, 32'd0, 4'hF, 32'd0, 1'b0, 8'd1},  // R1 status reads 0
        '{OP_WR, 8'h1C, 32'd1, 4'hF, 32'd0, 1'b0, 8'd6},  // R6 enable on
        '{OP_WR, 8'h00, 32'd4, 4'hF, 32'd0, 1'b0, 8'd2},  // R2 arm 4 from 0
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd0, 1'b0, 8'd4},  // R4 view 0
        '{OP_TK, 8'h00, 32'd1, 4'hF, 32'd0, 1'b0, 8'd4},
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd1, 1'b0, 8'd4},  // R4 view 1
        '{OP_TK, 8'h00, 32'd2, 4'hF, 32'd0, 1'b0, 8'd4},
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd3, 1'b0, 8'd4},  // R4 view 3
        '{OP_RD, 8'h14, 32'd0, 4'hF, 32'd0, 1'b0, 8'd2},  // R2 not yet done
        '{OP_TK, 8'h00, 32'd1, 4'hF, 32'd0, 1'b0, 8'd2},
        '{OP_RD, 8'h14, 32'd0, 4'hF, 32'd1, 1'b0, 8'd6},  // R6 status set
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd4, 1'b0, 8'd2},  // R2 counter = match
        '{OP_TK, 8'h00, 32'd3, 4'hF, 32'd0, 1'b0, 8'd5},
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd4, 1'b0, 8'd5},  // R5 counter holds
        '{OP_WR, 8'h14, 32'd0, 4'hF, 32'd0, 1'b0, 8'd8},  // R8 clear
        '{OP_WR, 8'h00, 32'd2, 4'hF, 32'd0, 1'b0, 8'd3},  // R3 arm 2 from 4
        '{OP_RD, 8'h10, 32'd0, 4'hF, 32'd5, 1'b0, 8'd3},  // R3 view = C+1
        '{OP_RD, 8'h30, 32'd0, 4'hF, 32'd0, 1'b1, 8'd10}  // R10 unmapped
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_be = 4'hF;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data_o;
    logic              err_o;
    logic              irq_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ostmr_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rd_data_o (rd_data_o),
        .err_o     (err_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One-cycle request issued at a falling edge; response sampled at the next one.
    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic tk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        tick_en   = tk;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_be    = 4'hF;
        tick_en   = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus(1'b0, a, 32'd0, 4'hF, 1'b0);
        check(tag, rd_data_o, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual 0x%08h expected 0x%08h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", 32'(irq_o), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            if (VECS[v].op == OP_TK) begin
                ticks(int'(VECS[v].data));
            end else begin
                bus(VECS[v].op == OP_WR, VECS[v].addr, VECS[v].data, VECS[v].be, 1'b0);
                check({tag, " err"}, 32'(err_o), 32'(VECS[v].experr));
                if (VECS[v].op == OP_RD) check({tag, " data"}, rd_data_o, VECS[v].exp);
            end
        end

        // R7: enable zero, run of 6 from latched 4 ends with no status
        bus(1'b1, 8'h1C, 32'd0, 4'hF, 1'b0);
        bus(1'b1, 8'h00, 32'd10, 4'hF, 1'b0);
        ticks(5);
        rd("R7 counter before end", 8'h10, 32'd9);
        ticks(1);
        check("R7 irq low", 32'(irq_o), 32'd0);
        rd("R7 status clear", 8'h14, 32'd0);
        rd("R7 counter snapped", 8'h10, 32'd10);

        // R6 / R9: pending status survives a new match write
        bus(1'b1, 8'h1C, 32'h8000_0000, 4'hF, 1'b0);
        bus(1'b1, 8'h00, 32'd12, 4'hF, 1'b0);
        ticks(1);
        check("R6 irq low mid-run", 32'(irq_o), 32'd0);
        ticks(1);
        check("R6 irq high", 32'(irq_o), 32'd1);
        bus(1'b1, 8'h00, 32'd20, 4'hF, 1'b0);
        check("R9 irq held", 32'(irq_o), 32'd1);
        rd("R9 status held", 8'h14, 32'd1);

        // R8: nonzero status write rejected, zero clears
        bus(1'b1, 8'h14, 32'd7, 4'hF, 1'b0);
        check("R8 nonzero err", 32'(err_o), 32'd1);
        check("R8 irq kept", 32'(irq_o), 32'd1);
        bus(1'b1, 8'h14, 32'd0, 4'hF, 1'b0);
        check("R8 irq dropped", 32'(irq_o), 32'd0);
        check("R8 clear no err", 32'(err_o), 32'd0);

        // R11: match write with tick in the same cycle, latched 12
        bus(1'b1, 8'h00, 32'd25, 4'hF, 1'b1);
        rd("R11 tick not counted", 8'h10, 32'd12);
        ticks(1);
        rd("R11 next tick counts", 8'h10, 32'd13);

        // R10: rejected accesses change nothing
        bus(1'b1, 8'h1C, 32'd0, 4'h3, 1'b0);
        check("R10 partial err", 32'(err_o), 32'd1);
        rd("R10 enable kept", 8'h1C, 32'h8000_0000);
        bus(1'b0, 8'h15, 32'd0, 4'hF, 1'b0);
        check("R10 misaligned err", 32'(err_o), 32'd1);
        check("R10 misaligned data", rd_data_o, 32'd0);
        bus(1'b0, 8'h00, 32'd0, 4'hF, 1'b0);
        check("R10 match read err", 32'(err_o), 32'd1);
        check("R10 match read data", rd_data_o, 32'd0);
        bus(1'b1, 8'h10, 32'd99, 4'hF, 1'b0);
        check("R10 counter write err", 32'(err_o), 32'd1);
        rd("R10 counter kept", 8'h10, 32'd13);
        check("R10 err one cycle", 32'(err_o), 32'd0);

        // R1: reset in the middle of a run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after mid-run reset", 32'(irq_o), 32'd0);
        rd("R1 counter zero", 8'h10, 32'd0);
        rd("R1 enable zero", 8'h1C, 32'd0);
        rd("R1 status zero", 8'h14, 32'd0);
        ticks(3);
        rd("R5 idle ticks ignored", 8'h10, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule